// File: doc/BRIEF.md
# Wiper Command Decoder and Register Bank

This block sits behind a two-wire serial slave front end and runs the command layer of a quad digital potentiometer. The front end strips the address byte, matches the device address and reports bus events. It passes on start and stop conditions as one-cycle pulses, received bytes as a byte strobe with data, and increment/decrement clock pulses as a step strobe with a direction bit. The block keeps four 6-bit wiper position registers. Each wiper has four 6-bit retained setting registers, sixteen in all. It decodes the first byte after a start as a command. That byte holds an opcode nibble, a setting-register index and a wiper index.

Commands that change a retained setting register take effect at the stop condition, and only when the write-enable input is high. After such a change the block raises `busy_o` for a fixed number of clock cycles to stand for the nonvolatile programming time. While `busy_o` is high the front end withholds its address acknowledge, and the block ignores every bus event. Position loads, position writes and stepping take effect at once. A synchronous reset stands for power-up: each wiper reloads from its setting register 0, and the setting registers keep their contents.

Top module: `wiper_cmd_bank`

## Requirements
- R1: The first byte after a start is the command: bits 7:4 are the opcode, bits 3:2 the setting-register index and bits 1:0 the wiper index. Bytes received outside a started frame, or after a command has finished, have no effect.
- R2: Opcode 1001 makes `rd_vld_o` pulse for one cycle, in the cycle after the command byte, with `rd_dat_o` = {2'b00, position of the indexed wiper}.
- R3: Opcode 1010 loads the indexed wiper from bits 5:0 of the next byte, in the cycle after that byte; bits 7:6 of the data byte are ignored.
- R4: Opcode 1011 makes `rd_vld_o` pulse in the cycle after the command byte, with `rd_dat_o` = {2'b00, indexed setting register of the indexed wiper}.
- R5: Opcode 1100 takes bits 5:0 of the next byte and writes them to the indexed setting register when the frame's stop arrives.
- R6: Opcode 1101 loads the indexed wiper from its indexed setting register. Opcode 0001 with wiper field 00 loads every wiper from its own setting register at the indexed slot. Both loads take effect in the cycle after the command byte and start no busy window. Opcode 0001 with a nonzero wiper field changes nothing.
- R7: Opcode 1110 saves the indexed wiper's position into its indexed setting register at the stop. Opcode 1000 with wiper field 00 does the same for all four wipers at the indexed slot.
- R8: A setting-register change made at a stop raises `busy_o` for exactly BUSY_CYC cycles, starting the cycle after the stop. While `busy_o` is high, starts, bytes, steps and stops have no effect.
- R9: With `wp_n` low at the stop, no setting register changes and `busy_o` stays low.
- R10: Opcodes 0000, 0011, 0100, 0101, 0110, 0111 and 1111 change no register and start no busy window. A 1010 or 1100 frame that reaches its stop before the data byte arrives changes nothing.
- R11: After opcode 0010, each `step_vld` pulse moves the indexed wiper one step, up when `step_up` is 1 and down when it is 0. The wiper holds at 63 and at 0. Step pulses outside stepping mode have no effect.
- R12: While `rst` is high, each wiper is loaded from its setting register 0, `busy_o` and `rd_vld_o` are low, and the setting registers keep their contents. The setting registers start at STORE_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up recall) |
| frm_start | input | 1 | Start condition seen, one-cycle pulse |
| frm_stop | input | 1 | Stop condition seen, one-cycle pulse |
| byte_vld | input | 1 | Received byte strobe |
| byte_dat | input | 8 | Received byte, bit 7 first on the wire |
| step_vld | input | 1 | Step clock pulse in stepping mode |
| step_up | input | 1 | Step direction, 1 = towards top |
| wp_n | input | 1 | Setting-register write enable, low blocks |
| busy_o | output | 1 | Programming window active |
| rd_vld_o | output | 1 | Read byte ready, one-cycle pulse |
| rd_dat_o | output | 8 | Byte to transmit for read commands |
| pos_o | output | NPOT*DW | Wiper positions, wiper k in bits k*DW +: DW |

## Verification
On every cycle the assertions check four things. A setting register changes only in the cycle after a stop. A busy window opens only after a stop with writes enabled. While busy, no wiper moves. Any read pulse follows an accepted byte. The bench scenarios are needed to show the rest: the decoded values and their targets across all wipers and slots, the exact busy length, saturation while stepping, discarded and undefined frames, and recall from slot 0 after reset.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
  localparam int PTR_W = 2;
  localparam int NPOT  = 1 << PTR_W;
  localparam int NREG  = 1 << PTR_W;

  typedef enum logic [3:0] {
    K_IGNORE, K_RD_POS, K_WR_POS, K_RD_ST, K_WR_ST,
    K_LD, K_LD_ALL, K_SAVE, K_SAVE_ALL, K_STEP
  } cmd_kind_e;

  typedef enum logic [3:0] {
    BK_NONE, BK_POS_WR, BK_POS_LD, BK_POS_LD_ALL,
    BK_ST_WR, BK_ST_SAVE, BK_ST_SAVE_ALL, BK_STEP_UP, BK_STEP_DN
  } bank_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_DATA, PH_STEP, PH_DONE
  } phase_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic [PTR_W-1:0] sel;
    logic [PTR_W-1:0] pot;
  } cmd_t;
endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_bank_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  logic [3:0] opc;
  logic       pot_zero;

  assign opc      = byte_i[7:4];
  assign pot_zero = (byte_i[1:0] == 2'b00);

  always_comb begin
    cmd_o.sel = byte_i[3:2];
    cmd_o.pot = byte_i[1:0];
    case (opc)
      4'b1001: cmd_o.kind = K_RD_POS;
      4'b1010: cmd_o.kind = K_WR_POS;
      4'b1011: cmd_o.kind = K_RD_ST;
      4'b1100: cmd_o.kind = K_WR_ST;
      4'b1101: cmd_o.kind = K_LD;
      4'b1110: cmd_o.kind = K_SAVE;
      4'b0001: cmd_o.kind = pot_zero ? K_LD_ALL : K_IGNORE;
      4'b1000: cmd_o.kind = pot_zero ? K_SAVE_ALL : K_IGNORE;
      4'b0010: cmd_o.kind = K_STEP;
      default: cmd_o.kind = K_IGNORE;
    endcase
  end
endmodule

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= CW'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wiper_reg_bank.sv
module wiper_reg_bank
  import wiper_bank_pkg::*;
#(
  parameter int             DW         = 6,
  parameter logic [DW-1:0]  STORE_INIT = DW'(32)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bank_op_e             op,
  input  logic [PTR_W-1:0]     pot,
  input  logic [PTR_W-1:0]     sel,
  input  logic [DW-1:0]        wdata,
  output logic [NPOT*DW-1:0]   pos_flat,
  output logic [NPOT*NREG*DW-1:0] st_flat
);
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  for (genvar g = 0; g < NPOT; g++) begin : g_pot
    logic [DW-1:0] st_q [NREG];
    logic [DW-1:0] pos_q;
    logic          hit;

    assign hit = (pot == PTR_W'(g));

    initial begin
      for (int i = 0; i < NREG; i++) st_q[i] = STORE_INIT;
    end

    always_ff @(posedge clk) begin
      case (op)
        BK_ST_WR:       if (hit) st_q[sel] <= wdata;
        BK_ST_SAVE:     if (hit) st_q[sel] <= pos_q;
        BK_ST_SAVE_ALL: st_q[sel] <= pos_q;
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pos_q <= st_q[0];
      end else begin
        case (op)
          BK_POS_WR:     if (hit) pos_q <= wdata;
          BK_POS_LD:     if (hit) pos_q <= st_q[sel];
          BK_POS_LD_ALL: pos_q <= st_q[sel];
          BK_STEP_UP:    if (hit && pos_q != MAXV) pos_q <= pos_q + 1'b1;
          BK_STEP_DN:    if (hit && pos_q != '0)   pos_q <= pos_q - 1'b1;
          default: ;
        endcase
      end
    end

    assign pos_flat[g*DW +: DW] = pos_q;
    for (genvar r = 0; r < NREG; r++) begin : g_slot
      assign st_flat[(g*NREG + r)*DW +: DW] = st_q[r];
    end
  end
endmodule

// File: rtl/wiper_cmd_bank.sv
module wiper_cmd_bank
  import wiper_bank_pkg::*;
#(
  parameter int            DW         = 6,
  parameter int            BUSY_CYC   = 250000,
  parameter logic [DW-1:0] STORE_INIT = DW'(32)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_start,
  input  logic                 frm_stop,
  input  logic                 byte_vld,
  input  logic [7:0]           byte_dat,
  input  logic                 step_vld,
  input  logic                 step_up,
  input  logic                 wp_n,
  output logic                 busy_o,
  output logic                 rd_vld_o,
  output logic [7:0]           rd_dat_o,
  output logic [NPOT*DW-1:0]   pos_o
);
  cmd_t             dec;
  cmd_t             cmd_q;
  phase_e           ph_q;
  logic             pend_q;
  bank_op_e         pend_op_q;
  logic [PTR_W-1:0] pend_pot_q, pend_sel_q;
  logic [DW-1:0]    pend_dat_q;
  logic             rd_vld_q;
  logic [7:0]       rd_dat_q;

  bank_op_e         op;
  logic [PTR_W-1:0] op_pot, op_sel;
  logic [DW-1:0]    op_dat;
  logic             commit;
  logic             live;

  logic [NPOT*DW-1:0]      pos_flat;
  logic [NPOT*NREG*DW-1:0] st_flat;
  logic [DW-1:0]           pos_a [NPOT];
  logic [DW-1:0]           st_a  [NPOT][NREG];

  for (genvar g = 0; g < NPOT; g++) begin : g_unpack
    assign pos_a[g] = pos_flat[g*DW +: DW];
    for (genvar r = 0; r < NREG; r++) begin : g_slot
      assign st_a[g][r] = st_flat[(g*NREG + r)*DW +: DW];
    end
  end

  wiper_cmd_decode u_dec (.byte_i(byte_dat), .cmd_o(dec));

  assign live   = !busy_o;
  assign commit = live && frm_stop && pend_q && wp_n;

  always_comb begin
    op     = BK_NONE;
    op_pot = dec.pot;
    op_sel = dec.sel;
    op_dat = byte_dat[DW-1:0];
    if (live && frm_stop) begin
      if (commit) begin
        op     = pend_op_q;
        op_pot = pend_pot_q;
        op_sel = pend_sel_q;
        op_dat = pend_dat_q;
      end
    end else if (live && !frm_start && byte_vld && ph_q == PH_CMD) begin
      if (dec.kind == K_LD)     op = BK_POS_LD;
      if (dec.kind == K_LD_ALL) op = BK_POS_LD_ALL;
    end else if (live && !frm_start && byte_vld && ph_q == PH_DATA) begin
      op_pot = cmd_q.pot;
      if (cmd_q.kind == K_WR_POS) op = BK_POS_WR;
    end else if (live && !frm_start && step_vld && ph_q == PH_STEP) begin
      op_pot = cmd_q.pot;
      op     = step_up ? BK_STEP_UP : BK_STEP_DN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      cmd_q      <= '0;
      pend_q     <= 1'b0;
      pend_op_q  <= BK_NONE;
      pend_pot_q <= '0;
      pend_sel_q <= '0;
      pend_dat_q <= '0;
      rd_vld_q   <= 1'b0;
      rd_dat_q   <= '0;
    end else begin
      rd_vld_q <= 1'b0;
      if (live) begin
        if (frm_stop) begin
          ph_q   <= PH_IDLE;
          pend_q <= 1'b0;
        end else if (frm_start) begin
          ph_q   <= PH_CMD;
          pend_q <= 1'b0;
        end else if (byte_vld) begin
          case (ph_q)
            PH_CMD: begin
              cmd_q      <= dec;
              pend_pot_q <= dec.pot;
              pend_sel_q <= dec.sel;
              ph_q       <= PH_DONE;
              case (dec.kind)
                K_RD_POS: begin
                  rd_vld_q <= 1'b1;
                  rd_dat_q <= 8'(pos_a[dec.pot]);
                end
                K_RD_ST: begin
                  rd_vld_q <= 1'b1;
                  rd_dat_q <= 8'(st_a[dec.pot][dec.sel]);
                end
                K_WR_POS, K_WR_ST: ph_q <= PH_DATA;
                K_SAVE: begin
                  pend_q    <= 1'b1;
                  pend_op_q <= BK_ST_SAVE;
                end
                K_SAVE_ALL: begin
                  pend_q    <= 1'b1;
                  pend_op_q <= BK_ST_SAVE_ALL;
                end
                K_STEP:  ph_q <= PH_STEP;
                default: ;
              endcase
            end
            PH_DATA: begin
              ph_q <= PH_DONE;
              if (cmd_q.kind == K_WR_ST) begin
                pend_q     <= 1'b1;
                pend_op_q  <= BK_ST_WR;
                pend_dat_q <= byte_dat[DW-1:0];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  wiper_reg_bank #(.DW(DW), .STORE_INIT(STORE_INIT)) u_bank (
    .clk(clk), .rst(rst), .op(op), .pot(op_pot), .sel(op_sel),
    .wdata(op_dat), .pos_flat(pos_flat), .st_flat(st_flat)
  );

  wiper_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .load(commit), .busy_o(busy_o)
  );

  assign rd_vld_o = rd_vld_q;
  assign rd_dat_o = rd_dat_q;
  assign pos_o    = pos_flat;
endmodule

// File: rtl/wiper_cmd_bank_chk.sv
module wiper_cmd_bank_chk #(
  parameter int DW   = 6,
  parameter int NPOT = 4,
  parameter int NREG = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      frm_stop,
  input logic                      byte_vld,
  input logic                      wp_n,
  input logic                      busy_o,
  input logic                      rd_vld_o,
  input logic [NPOT*DW-1:0]        pos_o,
  input logic [NPOT*NREG*DW-1:0]   st_flat
);
  // R5, R7: retained settings move only right after a stop
  a_r5_store_changes_at_stop: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_flat) |-> $past(frm_stop));

  // R8: a busy window opens only after a write-enabled stop
  a_r8_busy_only_after_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(frm_stop) && $past(wp_n)));

  // R8: nothing moves a wiper while busy
  a_r8_busy_freezes_pos: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(pos_o));

  // R9: a write-protected stop leaves the settings and busy alone
  a_r9_wp_keeps_store: assert property (@(posedge clk) disable iff (rst)
    (frm_stop && !wp_n) |=> ($stable(st_flat) && !$rose(busy_o)));

  // R2, R4: read pulse only after an accepted byte
  a_r2_read_follows_byte: assert property (@(posedge clk) disable iff (rst)
    rd_vld_o |-> ($past(byte_vld) && !$past(busy_o)));
endmodule

bind wiper_cmd_bank wiper_cmd_bank_chk #(
  .DW(DW), .NPOT(wiper_bank_pkg::NPOT), .NREG(wiper_bank_pkg::NREG)
) u_chk (
  .clk(clk), .rst(rst), .frm_stop(frm_stop), .byte_vld(byte_vld),
  .wp_n(wp_n), .busy_o(busy_o), .rd_vld_o(rd_vld_o), .pos_o(pos_o),
  .st_flat(st_flat)
);

// File: tb/wiper_cmd_bank_tb.sv
module wiper_cmd_bank_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 6;
  localparam int NP    = 4;
  localparam int BC    = 20;
  localparam int INIT  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 0, frm_stop = 0, byte_vld = 0, step_vld = 0, step_up = 0, wp_n = 1;
  logic [7:0] byte_dat = '0;
  logic busy_o, rd_vld_o;
  logic [7:0] rd_dat_o;
  logic [NP*DW-1:0] pos_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int ep [NP];
  int es [NP][NP];

  always #(CLK_P/2) clk = ~clk;

  wiper_cmd_bank #(.DW(DW), .BUSY_CYC(BC), .STORE_INIT(DW'(INIT))) u_dut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .step_vld(step_vld),
    .step_up(step_up), .wp_n(wp_n), .busy_o(busy_o), .rd_vld_o(rd_vld_o),
    .rd_dat_o(rd_dat_o), .pos_o(pos_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bstart();
    frm_start = 1; @(negedge clk); frm_start = 0;
  endtask
  task automatic bstop();
    frm_stop = 1; @(negedge clk); frm_stop = 0;
  endtask
  task automatic bbyte(input logic [7:0] b);
    byte_dat = b; byte_vld = 1; @(negedge clk); byte_vld = 0;
  endtask
  task automatic bstep(input logic up);
    step_up = up; step_vld = 1; @(negedge clk); step_vld = 0;
  endtask

  task automatic check_pos(string req);
    for (int p = 0; p < NP; p++) check(req, int'(pos_o[p*DW +: DW]), ep[p]);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 10*BC) begin n++; @(negedge clk); end
  endtask

  task automatic read_st(string req, int p, int r);
    bstart();
    bbyte({4'b1011, 2'(r), 2'(p)});
    check(req, int'(rd_vld_o), 1);
    check(req, int'(rd_dat_o), es[p][r]);
    bstop();
  endtask

  task automatic write_pos(int p, int v);
    bstart(); bbyte({4'b1010, 2'b00, 2'(p)}); bbyte(8'(v)); bstop();
    ep[p] = v & 63;
  endtask

  initial begin
    int n, v;
    for (int p = 0; p < NP; p++) begin
      ep[p] = INIT;
      for (int r = 0; r < NP; r++) es[p][r] = INIT;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    check_pos("R12 reset pos");
    check("R12 busy at reset", int'(busy_o), 0);
    check("R12 rd_vld at reset", int'(rd_vld_o), 0);

    // R1 bytes outside a frame do nothing
    bbyte(8'hA1); bbyte(8'h05);
    check_pos("R1 byte without start");

    // R3 / R2 position write and read, top data bits set
    for (int p = 0; p < NP; p++) begin
      v = (p*13 + 5) & 63;
      bstart(); bbyte({4'b1010, 2'b00, 2'(p)}); bbyte(8'hC0 | 8'(v));
      ep[p] = v;
      check_pos("R3 position write");
      bstop();
      check("R3 no busy", int'(busy_o), 0);
      bstart(); bbyte({4'b1001, 2'b00, 2'(p)});
      check("R2 read pulse", int'(rd_vld_o), 1);
      check("R2 read data", int'(rd_dat_o), v);
      @(negedge clk);
      check("R2 pulse one cycle", int'(rd_vld_o), 0);
      bbyte(8'h33);
      check("R1 byte after command", int'(rd_vld_o), 0);
      bstop();
    end

    // R5 / R8 / R4 stored writes over all slots
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NP; r++) begin
        v = (p*16 + r*5 + 7) & 63;
        bstart(); bbyte({4'b1100, 2'(r), 2'(p)}); bbyte(8'h40 | 8'(v)); bstop();
        es[p][r] = v;
        busy_len(n);
        check("R8 busy length", n, BC);
        read_st("R4 R5 stored readback", p, r);
      end

    // R8 events during busy ignored
    bstart(); bbyte({4'b1100, 2'b01, 2'b00}); bbyte(8'd9); bstop();
    es[0][1] = 9;
    check("R8 busy after stop", int'(busy_o), 1);
    bstart(); bbyte(8'hA0); bbyte(8'd1); bstop();
    bstart(); bbyte(8'h20); bstep(1'b1);
    busy_len(n);
    check_pos("R8 ignored while busy");
    bstep(1'b1);
    check_pos("R11 step without mode");
    bstop();
    read_st("R8 stored after busy", 0, 1);

    // R9 write protect
    wp_n = 0;
    bstart(); bbyte({4'b1100, 2'b11, 2'b10}); bbyte(8'(es[2][3] ^ 1)); bstop();
    check("R9 no busy on blocked write", int'(busy_o), 0);
    read_st("R9 stored unchanged", 2, 3);
    bstart(); bbyte({4'b1110, 2'b00, 2'b01}); bstop();
    check("R9 no busy on blocked save", int'(busy_o), 0);
    read_st("R9 save blocked", 1, 0);
    wp_n = 1;

    // R6 single and global loads
    bstart(); bbyte({4'b1101, 2'b01, 2'b11});
    ep[3] = es[3][1];
    check_pos("R6 single load");
    bstop();
    check("R6 load no busy", int'(busy_o), 0);
    bstart(); bbyte({4'b0001, 2'b10, 2'b00});
    for (int p = 0; p < NP; p++) ep[p] = es[p][2];
    check_pos("R6 global load");
    bstop();
    bstart(); bbyte({4'b0001, 2'b00, 2'b01}); bstop();
    check_pos("R6 global with wiper field ignored");

    // R7 single and global saves
    write_pos(1, 50);
    bstart(); bbyte({4'b1110, 2'b11, 2'b01}); bstop();
    es[1][3] = 50;
    busy_len(n);
    check("R7 save busy length", n, BC);
    read_st("R7 single save", 1, 3);
    bstart(); bbyte({4'b1000, 2'b00, 2'b00}); bstop();
    for (int p = 0; p < NP; p++) es[p][0] = ep[p];
    busy_len(n);
    check("R7 global save busy length", n, BC);
    for (int p = 0; p < NP; p++) read_st("R7 global save", p, 0);
    bstart(); bbyte({4'b1000, 2'b01, 2'b10}); bstop();
    check("R7 global save with wiper field ignored", int'(busy_o), 0);

    // R10 undefined opcodes
    foreach (ep[i]) ;
    for (int k = 0; k < 7; k++) begin
      logic [3:0] opc;
      case (k)
        0: opc = 4'h0; 1: opc = 4'h3; 2: opc = 4'h4; 3: opc = 4'h5;
        4: opc = 4'h6; 5: opc = 4'h7; default: opc = 4'hF;
      endcase
      bstart(); bbyte({opc, 4'b0110}); bbyte(8'h2A); bstop();
      check("R10 undefined no busy", int'(busy_o), 0);
      check_pos("R10 undefined no change");
    end
    read_st("R10 stored untouched", 2, 1);
    // R10 truncated writes
    bstart(); bbyte({4'b1100, 2'b01, 2'b10}); bstop();
    check("R10 truncated store no busy", int'(busy_o), 0);
    read_st("R10 truncated store", 2, 1);
    bstart(); bbyte({4'b1010, 2'b00, 2'b10}); bstop();
    check_pos("R10 truncated position write");

    // R11 stepping with saturation
    write_pos(1, 61);
    bstart(); bbyte({4'b0010, 2'b00, 2'b01});
    for (int i = 0; i < 4; i++) begin
      bstep(1'b1);
      ep[1] = (ep[1] + 1 > 63) ? 63 : ep[1] + 1;
      check_pos("R11 step up");
    end
    bstep(1'b0); ep[1] = 62;
    check_pos("R11 step down");
    bstop();
    write_pos(1, 2);
    bstart(); bbyte({4'b0010, 2'b00, 2'b01});
    for (int i = 0; i < 5; i++) begin
      bstep(1'b0);
      ep[1] = (ep[1] == 0) ? 0 : ep[1] - 1;
      check_pos("R11 step down floor");
    end
    bstop();
    bstep(1'b1);
    check_pos("R11 step after stop");

    // R12 recall from slot 0, settings kept
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    for (int p = 0; p < NP; p++) ep[p] = es[p][0];
    check_pos("R12 recall slot 0");
    read_st("R12 settings kept", 3, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule